// File: doc/BRIEF.md
# Banked Configuration Register Interface

This block keeps the 16-bit read-setup word of a two-bank burst memory controller. The word has no address in the memory map. Software reaches it only through dedicated commands on a small command port: enter register-read mode, write the register, and leave register-read mode. The data bus is 32 bits wide. A bus-width select says whether the upper half of the bus is in use.

When register-read mode is entered, the block latches the bank address presented with that command. While the mode is active, reads that target the latched bank return the register word, zero-extended. Reads that target the other bank pass the array data through unchanged. A write is accepted only while the embedded program/erase engine is idle. A write that arrives while the engine is busy is dropped silently. The stored word is also decoded into the fields the burst logic uses: read mode, output clock edge, data hold length and burst length.

Top module: `cfgreg_bank_if`

## Requirements
- R1: After a synchronous reset, the stored word is 0x8040. This means asynchronous read mode, output on the rising edge, a one-clock hold and burst-length code 0. After reset, `rd_valid` is 0, `rd_data` is 0 and register-read mode is off.
- R2: A register write takes only data bits 15..0, in either bus-width mode. Bits 31..16 of `wr_data` have no effect. Reserved bits 14, 5, 4 and 3 are stored as 0 whatever value is written. All other bits take the written value.
- R3: A register write issued while `algo_busy` is 1 is discarded, and the stored word keeps its previous value.
- R4: An enter command latches `cmd_bank`. One cycle after a read strobe to the latched bank, `rd_data` is `{16'h0000, word}`, with bits 31..16 equal to zero. A read to the other bank returns array data.
- R5: The enter command is accepted with bank address 0 and with bank address 1. A later enter command re-latches the bank.
- R6: An exit command ends register-read mode, and so does a reset. After either, reads to both banks return array data.
- R7: The decoded outputs follow the stored word from the cycle after a write: `cfg_async_rd` is bit 15, `cfg_rise_edge` is bit 6, `cfg_hold2` is bit 9 and `cfg_burst_len` is bits 2..0.
- R8: When `wide_bus` is 0, an array read returns bits 31..16 as zero and bits 15..0 from the array. When `wide_bus` is 1, all 32 bits pass through.
- R9: The register can be read while `algo_busy` is 1.
- R10: A command acts only while `cmd_valid` is 1. The codes on `cmd_op` are: 2'b00 none, 2'b01 enter register-read mode, 2'b10 write register, 2'b11 exit.
- R11: `rd_valid` is 1 exactly one cycle after a cycle with `rd_en` at 1, and 0 otherwise. `rd_data` is registered with the same one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code |
| cmd_bank | input | 1 | Bank address presented with the command |
| wr_data | input | 32 | Write data bus |
| wide_bus | input | 1 | 1 = 32-bit bus, 0 = 16-bit bus |
| algo_busy | input | 1 | Embedded program/erase engine active |
| rd_en | input | 1 | Read strobe |
| rd_bank | input | 1 | Bank targeted by the read |
| array_data | input | 32 | Data from the memory array |
| rd_data | output | 32 | Read result |
| rd_valid | output | 1 | Read result valid |
| cfg_async_rd | output | 1 | 1 = asynchronous reads, 0 = synchronous burst |
| cfg_rise_edge | output | 1 | 1 = drive burst data on the rising edge |
| cfg_hold2 | output | 1 | 1 = hold each burst word for two clocks |
| cfg_burst_len | output | 3 | Burst length code |

## Verification
Writes are swept with scrambled 32-bit patterns in every combination of bus width and busy state. Each write is followed by a look at the decoded fields. This separates dropped writes from accepted ones and shows whether reserved bits are cleared. Reads are then made for every pairing of latched bank and read bank, in both bus widths, with array data that differs from the register word. That separates register steering from array pass-through and tells narrow zero-fill apart from the zero-extension of the register. Commands without a valid strobe, re-entry to the other bank, exit, reset during the mode, and reads while busy each check one edge of the mode state.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    localparam int CFG_W = 16;

    // reset word: async reads (bit 15), rising edge (bit 6)
    localparam logic [CFG_W-1:0] CFG_DEFAULT = 16'h8040;
    // writable bits; 14, 5, 4, 3 are reserved
    localparam logic [CFG_W-1:0] CFG_WMASK   = 16'hBFC7;

    localparam int BIT_ASYNC = 15;
    localparam int BIT_HOLD2 = 9;
    localparam int BIT_EDGE  = 6;
    localparam int BL_LSB    = 0;
    localparam int BL_W      = 3;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_ENTER = 2'b01,
        OP_WRITE = 2'b10,
        OP_EXIT  = 2'b11
    } cfg_op_e;

    typedef struct packed {
        logic enter;
        logic write;
        logic leave;
    } cmd_pulse_t;

    typedef struct packed {
        logic            async_rd;
        logic            hold2;
        logic            rise_edge;
        logic [BL_W-1:0] burst_len;
    } cfg_fields_t;

    function automatic logic [CFG_W-1:0] scrub_word(input logic [CFG_W-1:0] w);
        return w & CFG_WMASK;
    endfunction

    function automatic cfg_fields_t split_word(input logic [CFG_W-1:0] w);
        cfg_fields_t f;
        f.async_rd  = w[BIT_ASYNC];
        f.hold2     = w[BIT_HOLD2];
        f.rise_edge = w[BIT_EDGE];
        f.burst_len = w[BL_LSB +: BL_W];
        return f;
    endfunction

endpackage

// File: rtl/cfgreg_cmd_dec.sv
module cfgreg_cmd_dec
    import cfgreg_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output cmd_pulse_t pulses
);
    cfg_op_e op;

    always_comb begin
        op = cfg_op_e'(cmd_op);
        pulses = '0;
        if (cmd_valid) begin
            unique case (op)
                OP_ENTER: pulses.enter = 1'b1;
                OP_WRITE: pulses.write = 1'b1;
                OP_EXIT:  pulses.leave = 1'b1;
                default:  pulses = '0;
            endcase
        end
    end

    // R10: at most one action per command
    always_comb begin
        p_onehot_cmd_r10: assert ($onehot0({pulses.enter, pulses.write, pulses.leave}));
    end

endmodule

// File: rtl/cfgreg_store.sv
module cfgreg_store
    import cfgreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_req,
    input  logic             busy,
    input  logic [CFG_W-1:0] wr_word,
    output logic [CFG_W-1:0] word_q,
    output cfg_fields_t      fields
);
    logic accept;

    assign accept = wr_req && !busy;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= CFG_DEFAULT;
        else if (accept)
            word_q <= scrub_word(wr_word);
    end

    assign fields = split_word(word_q);

    p_busy_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_req && busy) |=> $stable(word_q));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> $stable(word_q));

    p_reset_word_r1: assert property (@(posedge clk)
        rst |=> (word_q == CFG_DEFAULT));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> ((word_q & ~CFG_WMASK) == '0));

endmodule

// File: rtl/cfgreg_rd_steer.sv
module cfgreg_rd_steer
    import cfgreg_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              enter,
    input  logic              leave,
    input  logic              cmd_bank,
    input  logic              rd_en,
    input  logic              rd_bank,
    input  logic              wide_bus,
    input  logic [CFG_W-1:0]  word_q,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int LANES = DATA_W / CFG_W;
    localparam int UP_W  = DATA_W - CFG_W;

    logic              mode_q;
    logic              bank_q;
    logic              hit_cfg;
    logic [DATA_W-1:0] arr_lanes;
    logic [DATA_W-1:0] cfg_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            bank_q <= 1'b0;
        end else if (enter) begin
            mode_q <= 1'b1;
            bank_q <= cmd_bank;
        end else if (leave) begin
            mode_q <= 1'b0;
        end
    end

    // lane 0 always passes; upper lanes only on the wide bus
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign arr_lanes[CFG_W-1:0] = array_data[CFG_W-1:0];
        end else begin : g_high
            assign arr_lanes[g*CFG_W +: CFG_W] =
                wide_bus ? array_data[g*CFG_W +: CFG_W] : '0;
        end
    end

    assign cfg_ext = {{UP_W{1'b0}}, word_q};
    assign hit_cfg = mode_q && (rd_bank == bank_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= hit_cfg ? cfg_ext : arr_lanes;
        end
    end

    p_cfg_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && mode_q && rd_bank == bank_q) |=> (rd_data[DATA_W-1:CFG_W] == '0));

    p_leave_clears_r6: assert property (@(posedge clk) disable iff (rst)
        leave |=> !mode_q);

    p_enter_sets_r5: assert property (@(posedge clk) disable iff (rst)
        enter |=> (mode_q && bank_q == $past(cmd_bank)));

    p_narrow_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wide_bus) |=> (rd_data[DATA_W-1:CFG_W] == '0));

    p_valid_rise_r11: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    p_valid_fall_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

endmodule

// File: rtl/cfgreg_bank_if.sv
module cfgreg_bank_if
    import cfgreg_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_bank,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wide_bus,
    input  logic              algo_busy,
    input  logic              rd_en,
    input  logic              rd_bank,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              cfg_async_rd,
    output logic              cfg_rise_edge,
    output logic              cfg_hold2,
    output logic [BL_W-1:0]   cfg_burst_len
);
    cmd_pulse_t       pulses;
    logic [CFG_W-1:0] word_q;
    cfg_fields_t      fields;

    initial begin
        p_width_ok: assert (DATA_W > CFG_W && DATA_W % CFG_W == 0);
    end

    cfgreg_cmd_dec u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .pulses    (pulses)
    );

    // only the low half of the bus reaches the register
    cfgreg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (pulses.write),
        .busy    (algo_busy),
        .wr_word (wr_data[CFG_W-1:0]),
        .word_q  (word_q),
        .fields  (fields)
    );

    cfgreg_rd_steer #(.DATA_W(DATA_W)) u_steer (
        .clk        (clk),
        .rst        (rst),
        .enter      (pulses.enter),
        .leave      (pulses.leave),
        .cmd_bank   (cmd_bank),
        .rd_en      (rd_en),
        .rd_bank    (rd_bank),
        .wide_bus   (wide_bus),
        .word_q     (word_q),
        .array_data (array_data),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    assign cfg_async_rd  = fields.async_rd;
    assign cfg_rise_edge = fields.rise_edge;
    assign cfg_hold2     = fields.hold2;
    assign cfg_burst_len = fields.burst_len;

    p_fields_track_r7: assert property (@(posedge clk) disable iff (rst)
        (pulses.write && !algo_busy) |=>
            (cfg_async_rd == $past(wr_data[15]) && cfg_hold2 == $past(wr_data[9]) &&
             cfg_rise_edge == $past(wr_data[6]) && cfg_burst_len == $past(wr_data[2:0])));

endmodule

// File: tb/cfgreg_bank_if_bench.sv
module cfgreg_bank_if_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic        cmd_bank;
    logic [31:0] wr_data;
    logic        wide_bus;
    logic        algo_busy;
    logic        rd_en;
    logic        rd_bank;
    logic [31:0] array_data;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        cfg_async_rd;
    logic        cfg_rise_edge;
    logic        cfg_hold2;
    logic [2:0]  cfg_burst_len;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic [15:0] m_word;
    logic        m_mode;
    logic        m_bank;

    always #5 clk = ~clk;

    cfgreg_bank_if u_cfgreg_bank_if (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .cmd_bank      (cmd_bank),
        .wr_data       (wr_data),
        .wide_bus      (wide_bus),
        .algo_busy     (algo_busy),
        .rd_en         (rd_en),
        .rd_bank       (rd_bank),
        .array_data    (array_data),
        .rd_data       (rd_data),
        .rd_valid      (rd_valid),
        .cfg_async_rd  (cfg_async_rd),
        .cfg_rise_edge (cfg_rise_edge),
        .cfg_hold2     (cfg_hold2),
        .cfg_burst_len (cfg_burst_len)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_fields(input string req);
        check(req, {28'h0, cfg_async_rd, cfg_rise_edge, cfg_hold2, 1'b0},
              {28'h0, m_word[15], m_word[6], m_word[9], 1'b0});
        check(req, {29'h0, cfg_burst_len}, {29'h0, m_word[2:0]});
    endtask

    task automatic send(input logic [1:0] op, input logic bank, input logic [31:0] d,
                        input logic wide, input logic busy, input logic valid);
        @(negedge clk);
        cmd_valid = valid; cmd_op = op; cmd_bank = bank;
        wr_data = d; wide_bus = wide; algo_busy = busy;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00; algo_busy = 1'b0;
        if (valid) begin
            case (op)
                2'b01: begin m_mode = 1'b1; m_bank = bank; end
                2'b10: if (!busy) m_word = d[15:0] & 16'hBFC7;
                2'b11: m_mode = 1'b0;
                default: ;
            endcase
        end
    endtask

    task automatic rd(input string req, input logic bank, input logic [31:0] arr,
                      input logic wide, input logic busy);
        logic [31:0] exp;
        @(negedge clk);
        rd_en = 1'b1; rd_bank = bank; array_data = arr;
        wide_bus = wide; algo_busy = busy;
        if (m_mode && bank == m_bank) exp = {16'h0000, m_word};
        else exp = wide ? arr : {16'h0000, arr[15:0]};
        @(negedge clk);
        rd_en = 1'b0; algo_busy = 1'b0;
        check({req, " valid R11"}, {31'h0, rd_valid}, 32'h1);
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_bank = 1'b0;
        wr_data = '0; wide_bus = 1'b1; algo_busy = 1'b0;
        rd_en = 1'b0; rd_bank = 1'b0; array_data = '0;
        m_word = 16'h8040; m_mode = 1'b0; m_bank = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 async", {31'h0, cfg_async_rd}, 32'h1);
        check("R1 edge", {31'h0, cfg_rise_edge}, 32'h1);
        check("R1 hold", {31'h0, cfg_hold2}, 32'h0);
        check("R1 burst", {29'h0, cfg_burst_len}, 32'h0);
        check("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        check("R1 rd_data", rd_data, 32'h0);
        // R1/R6: no mode after reset, both banks give array data
        rd("R1 bank0 array", 1'b0, 32'hCAFE_0001, 1'b1, 1'b0);
        rd("R1 bank1 array", 1'b1, 32'hCAFE_0002, 1'b1, 1'b0);

        // R11 idle cycle after a read
        @(negedge clk);
        check("R11 idle", {31'h0, rd_valid}, 32'h0);

        // sweep of writes and steered reads
        for (int i = 0; i < 64; i++) begin
            logic [31:0] d;
            logic [31:0] arr;
            d   = (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
            arr = ~d ^ (i << 20);
            send(2'b10, i[4], d, i[0], i[1], 1'b1);
            if (i[1]) check_fields("R3 busy write dropped");
            else      check_fields("R2 R7 write fields");
            if (i[3:2] == 2'b00) begin
                send(2'b01, i[4], 32'h0, 1'b1, 1'b0, 1'b1);
                for (int b = 0; b < 2; b++) begin
                    for (int w = 0; w < 2; w++) begin
                        rd("R4 R5 R8 steer", b[0], arr, w[0], 1'b0);
                    end
                end
                rd("R9 read while busy", i[4], arr, 1'b1, 1'b1);
                send(2'b11, 1'b0, 32'h0, 1'b1, 1'b0, 1'b1);
                rd("R6 after exit", i[4], arr, 1'b0, 1'b0);
                rd("R6 after exit other", ~i[4], arr, 1'b1, 1'b0);
            end
        end

        // R2 explicit: upper bits ignored, reserved bits read 0
        send(2'b10, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1);
        send(2'b01, 1'b1, 32'h0, 1'b1, 1'b0, 1'b1);
        rd("R2 reserved cleared", 1'b1, 32'h1234_5678, 1'b1, 1'b0);
        check("R2 word value", rd_data, 32'h0000_BFC7);
        send(2'b10, 1'b0, 32'hABCD_0000, 1'b1, 1'b0, 1'b1);
        rd("R2 upper ignored", 1'b1, 32'h1111_2222, 1'b1, 1'b0);
        check("R2 zero word", rd_data, 32'h0000_0000);

        // R10 command without strobe has no effect
        send(2'b10, 1'b0, 32'h0000_8247, 1'b1, 1'b0, 1'b0);
        rd("R10 no strobe write", 1'b1, 32'h3333_4444, 1'b1, 1'b0);
        send(2'b11, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
        rd("R10 no strobe exit", 1'b1, 32'h5555_6666, 1'b1, 1'b0);

        // R5 re-enter with the other bank
        send(2'b10, 1'b0, 32'h0000_8247, 1'b1, 1'b0, 1'b1);
        send(2'b01, 1'b0, 32'h0, 1'b1, 1'b0, 1'b1);
        rd("R5 re-latched bank0", 1'b0, 32'h7777_8888, 1'b1, 1'b0);
        rd("R5 bank1 now array", 1'b1, 32'h7777_8888, 1'b1, 1'b0);
        check("R5 array value", rd_data, 32'h7777_8888);

        // R6 reset ends the mode and restores the word
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_mode = 1'b0; m_word = 16'h8040;
        check_fields("R1 fields after reset");
        rd("R6 reset clears mode", 1'b0, 32'h9999_AAAA, 1'b1, 1'b0);
        check("R6 array after reset", rd_data, 32'h9999_AAAA);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule